// File: doc/BRIEF.md
# Edge Interrupt and Event Controller

This block watches a port of asynchronous digital input lines and turns selected transitions on them into two kinds of notification. Every line carries its own choice of rising edge, falling edge or both. A detected edge can latch a per-line pending flag. The OR of all pending flags drives one shared interrupt request for the whole port. The same edge can also produce a single-cycle event strobe on that line's own output, which goes straight to another on-chip unit. Each path has its own mask bit.

Software programs the block through a small word-wide register port. The interrupt handler reads the pending register to find out which lines need service. The flags show which lines are latched at the moment of the read, not the order in which they arrived. The handler then writes ones to release them. A software trigger register lets code stand in for a real edge on any line.

Each line has a two-state controller: `LN_IDLE` (no request latched) and `LN_PEND` (request latched). The transition `LN_IDLE -> LN_PEND` is taken on a qualified hit while the interrupt mask is set. The transition `LN_PEND -> LN_IDLE` is taken on a write-one-to-clear of that line when no new qualified hit arrives in the same cycle. Otherwise each state holds.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, all registers read 0, `irq_o` is low and `evt_o` is all zero.
- R2: Register map, by `reg_addr`: 0 rising-edge select, 1 falling-edge select, 2 interrupt mask, 3 event mask, 4 software trigger (write 1 to set), 5 pending (read; write 1 to clear). Bit i of each register belongs to line i.
- R3: A low-to-high change on a line whose rising-edge select and interrupt mask bits are set sets its pending bit. The bit and `irq_o` are visible after the third rising clock edge following the input change.
- R4: A high-to-low change on a line whose falling-edge select bit is set is detected in the same way. A change in a direction that is not selected leaves pending and `evt_o` at zero.
- R5: A detected edge on a line whose event mask bit is set raises that line's `evt_o` bit for exactly one clock cycle, in the same cycle the pending bit would set. No pending bit is latched when that line's interrupt mask bit is 0.
- R6: `irq_o` is high exactly while at least one pending bit is set. Several lines can be pending at once, and all of them show in the pending register.
- R7: A pending bit holds until a 1 is written to its position at address 5. Writing 0 to a position leaves it unchanged.
- R8: Writing 1 to a software trigger bit acts as a detected edge on that line in the write cycle. Pending and event are visible after that clock edge, and the trigger bit reads back as 1.
- R9: A software trigger bit clears in the cycle its pending bit is cleared.
- R10: If a qualified edge on a line arrives in the same cycle as a clear of its pending bit, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | N_LINES | Asynchronous input lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | N_LINES | Write data |
| reg_rdata | output | N_LINES | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Shared interrupt request for the port |
| evt_o | output | N_LINES | Per-line single-cycle event strobes |

## Verification
A pin change causes a result three rising edges later: two synchroniser stages, then the pending and event registers. The bench drives pins on falling edges, waits exactly three rising edges and samples at the next falling edge. It samples again one cycle later to confirm that the strobe has dropped. A software trigger or clear write takes effect at the rising edge that captures the write, so the bench samples at the falling edge right after it. The coincident-clear case lines up the register write with the third edge after a pin change.

// File: rtl/eic_pkg.sv
package eic_pkg;
    typedef enum logic [2:0] {
        RA_RISE  = 3'd0,
        RA_FALL  = 3'd1,
        RA_IMASK = 3'd2,
        RA_EMASK = 3'd3,
        RA_SWTRG = 3'd4,
        RA_PEND  = 3'd5
    } reg_addr_e;

    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_PEND = 1'b1
    } line_state_e;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[0] <= '0;
                    else        stg_q[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '0;
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/eic_line.sv
module eic_line
    import eic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    input  logic rise_en,
    input  logic fall_en,
    input  logic imask,
    input  logic emask,
    input  logic sw_set,
    input  logic pend_clr,
    output logic hit,
    output logic pend,
    output logic evt,
    output logic trig
);
    logic        prev_q;
    logic        evt_q;
    logic        trig_q;
    logic        latch;
    line_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp;
    end

    assign hit   = (rise_en & smp & ~prev_q) | (fall_en & ~smp & prev_q) | sw_set;
    assign latch = hit & imask;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LN_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LN_IDLE: if (latch)               st_d = LN_PEND;
            LN_PEND: if (pend_clr && !latch)  st_d = LN_IDLE;
            default:                          st_d = LN_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q  <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            evt_q <= hit & emask;
            if (sw_set)
                trig_q <= 1'b1;
            else if (st_q == LN_PEND && st_d == LN_IDLE)
                trig_q <= 1'b0;
        end
    end

    assign pend = (st_q == LN_PEND);
    assign evt  = evt_q;
    assign trig = trig_q;
endmodule

// File: rtl/eic_regs.sv
module eic_regs
    import eic_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pend,
    input  logic [W-1:0] trig,
    output logic [W-1:0] rise_en,
    output logic [W-1:0] fall_en,
    output logic [W-1:0] imask,
    output logic [W-1:0] emask,
    output logic [W-1:0] sw_set,
    output logic [W-1:0] pend_clr,
    output logic [W-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
            imask   <= '0;
            emask   <= '0;
        end else if (wr) begin
            case (addr)
                RA_RISE:  rise_en <= wdata;
                RA_FALL:  fall_en <= wdata;
                RA_IMASK: imask   <= wdata;
                RA_EMASK: emask   <= wdata;
                default:  ;
            endcase
        end
    end

    assign sw_set   = (wr && addr == RA_SWTRG) ? wdata : '0;
    assign pend_clr = (wr && addr == RA_PEND)  ? wdata : '0;

    always_comb begin
        case (addr)
            RA_RISE:  rdata = rise_en;
            RA_FALL:  rdata = fall_en;
            RA_IMASK: rdata = imask;
            RA_EMASK: rdata = emask;
            RA_SWTRG: rdata = trig;
            RA_PEND:  rdata = pend;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] pin_i,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [N_LINES-1:0] reg_wdata,
    output logic [N_LINES-1:0] reg_rdata,
    output logic               irq_o,
    output logic [N_LINES-1:0] evt_o
);
    localparam int SYNC_STAGES = 2;

    logic [N_LINES-1:0] smp_v, rise_v, fall_v, imask_v, emask_v;
    logic [N_LINES-1:0] set_v, clr_v, hit_v, pend_v, trig_v;

    eic_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_i), .q(smp_v)
    );

    eic_regs #(.W(N_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .pend(pend_v), .trig(trig_v),
        .rise_en(rise_v), .fall_en(fall_v), .imask(imask_v), .emask(emask_v),
        .sw_set(set_v), .pend_clr(clr_v), .rdata(reg_rdata)
    );

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_line
            eic_line u_line (
                .clk(clk), .rst_n(rst_n), .smp(smp_v[i]),
                .rise_en(rise_v[i]), .fall_en(fall_v[i]),
                .imask(imask_v[i]), .emask(emask_v[i]),
                .sw_set(set_v[i]), .pend_clr(clr_v[i]),
                .hit(hit_v[i]), .pend(pend_v[i]),
                .evt(evt_o[i]), .trig(trig_v[i])
            );
        end
    endgenerate

    assign irq_o = |pend_v;
endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] pend_v,
    input logic [N-1:0] clr_v,
    input logic [N-1:0] imask_v,
    input logic [N-1:0] emask_v,
    input logic [N-1:0] hit_v,
    input logic [N-1:0] trig_v,
    input logic [N-1:0] evt_o,
    input logic         irq_o
);
    // R7: a pending bit only drops after a clear of that bit
    p_hold_until_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_v) & ~$past(clr_v)) & ~pend_v) == '0));

    // R5: a newly latched pending bit needs the interrupt mask
    p_latch_needs_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_v & ~$past(pend_v) & ~$past(imask_v)) == '0));

    // R5: an event strobe needs the event mask
    p_evt_needs_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_o & ~$past(emask_v)) == '0));

    // R9: the trigger bit is gone once its pending bit drops
    p_trig_follows_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~pend_v & $past(pend_v) & trig_v) == '0));

    // R10: a qualified hit always leaves the bit pending
    p_hit_not_lost_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(hit_v) & $past(imask_v)) & ~pend_v) == '0));

    // R6: the shared request rises only with a pending line
    p_irq_has_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (pend_v != '0));
endmodule

bind edge_irq_ctrl edge_irq_chk #(.N(N_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .pend_v(pend_v), .clr_v(clr_v),
    .imask_v(imask_v), .emask_v(emask_v), .hit_v(hit_v),
    .trig_v(trig_v), .evt_o(evt_o), .irq_o(irq_o)
);

// File: tb/tb_edge_irq_ctrl.sv
module tb_edge_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_i = '0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq_o;
    logic [N-1:0] evt_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_irq_ctrl #(.N_LINES(N)) dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .evt_o(evt_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(a[2:0], v);
            check("R1 reg", {24'd0, v}, 32'd0);
        end
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        check("R1 evt", {24'd0, evt_o}, 32'd0);
    endtask

    task automatic t_config();
        logic [N-1:0] v;
        wr(3'd0, 8'h0F); wr(3'd1, 8'h3C); wr(3'd2, 8'h07); wr(3'd3, 8'h09);
        rd(3'd0, v); check("R2 rise", {24'd0, v}, 32'h0F);
        rd(3'd1, v); check("R2 fall", {24'd0, v}, 32'h3C);
        rd(3'd2, v); check("R2 imask", {24'd0, v}, 32'h07);
        rd(3'd3, v); check("R2 emask", {24'd0, v}, 32'h09);
    endtask

    // line 0: rise sel, imask, emask
    task automatic t_rise();
        logic [N-1:0] v;
        pin_i[0] = 1'b1;
        step(); step();
        check("R3 not early", {31'd0, irq_o}, 32'd0);
        step();
        rd(3'd5, v);
        check("R3 pend", {24'd0, v}, 32'h01);
        check("R3 irq", {31'd0, irq_o}, 32'd1);
        check("R5 evt on", {24'd0, evt_o}, 32'h01);
        step();
        check("R5 evt one cycle", {24'd0, evt_o}, 32'h00);
    endtask

    // line 0 falls: fall not selected on line 0
    task automatic t_unselected();
        logic [N-1:0] v;
        wr(3'd5, 8'h01);
        pin_i[0] = 1'b0;
        step(); step(); step();
        rd(3'd5, v);
        check("R4 unselected pend", {24'd0, v}, 32'h00);
        check("R4 unselected evt", {24'd0, evt_o}, 32'h00);
    endtask

    // line 2: rise+fall, imask; fall path
    task automatic t_fall();
        logic [N-1:0] v;
        pin_i[2] = 1'b1;
        step(); step(); step(); step();
        wr(3'd5, 8'h04);
        rd(3'd5, v); check("R7 cleared", {24'd0, v}, 32'h00);
        pin_i[2] = 1'b0;
        step(); step(); step();
        rd(3'd5, v); check("R4 fall pend", {24'd0, v}, 32'h04);
        wr(3'd5, 8'h00);
        rd(3'd5, v); check("R7 zero write", {24'd0, v}, 32'h04);
    endtask

    // line 3: rise, emask, no imask -> event only
    task automatic t_event_only();
        logic [N-1:0] v;
        wr(3'd5, 8'h04);
        pin_i[3] = 1'b1;
        step(); step(); step();
        check("R5 evt only", {24'd0, evt_o}, 32'h08);
        rd(3'd5, v); check("R5 no pend", {24'd0, v}, 32'h00);
        check("R5 no irq", {31'd0, irq_o}, 32'd0);
        step();
        check("R5 evt drop", {24'd0, evt_o}, 32'h00);
    endtask

    // soft trigger lines 1 and 2, shared irq
    task automatic t_soft();
        logic [N-1:0] v;
        wr(3'd4, 8'h06);
        rd(3'd5, v); check("R8 soft pend", {24'd0, v}, 32'h06);
        rd(3'd4, v); check("R8 trig readback", {24'd0, v}, 32'h06);
        check("R6 irq multi", {31'd0, irq_o}, 32'd1);
        wr(3'd5, 8'h02);
        rd(3'd4, v); check("R9 trig self-clear", {24'd0, v}, 32'h04);
        check("R6 irq one left", {31'd0, irq_o}, 32'd1);
        wr(3'd5, 8'h04);
        rd(3'd4, v); check("R9 trig all clear", {24'd0, v}, 32'h00);
        check("R6 irq low", {31'd0, irq_o}, 32'd0);
    endtask

    // line 1 pending via soft, pin edge hits in the clear cycle
    task automatic t_collide();
        logic [N-1:0] v;
        wr(3'd4, 8'h02);
        pin_i[1] = 1'b1;
        step(); step();
        wr(3'd5, 8'h02);
        rd(3'd5, v); check("R10 kept", {24'd0, v}, 32'h02);
        rd(3'd4, v); check("R10 trig kept", {24'd0, v}, 32'h02);
        wr(3'd5, 8'h02);
        rd(3'd5, v); check("R7 final clear", {24'd0, v}, 32'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_config();
        t_rise();
        t_unselected();
        t_fall();
        t_event_only();
        t_soft();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule